// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register set of a simple LCD controller. A host reaches it over a 32-bit register bus with a word index, a write strobe, a read strobe and registered read data. It holds a control word, two size/timing words, a raw timing word, a status word and a sub-panel word. It decodes the configuration fields for the pixel and timing engines. It also turns the pulses those engines send into sticky status flags and one combined interrupt.

Turning the display on or off is done by changing the enable bit in the control word. The block reports each change as a one-cycle pulse. The same change also drives the status flags. Turning off clears the sync-error flag and marks the frame as done, except in the palette-only loading mode. Turning on clears the frame-done and palette-done flags so that a new frame sequence starts clean. Read-back does not always return what was written: some fixed bits read as one, one control bit appears in two places, and sizes are held as the value minus one.

Top module: `lcdr_regfile`

## Requirements
- R1: After a synchronous active-low reset, every field, flag, size and timing value is zero, irq is 0, and reads return only the forced constant bits (control 0xFE000C34, first timing word 0x0000000F, raw timing 0xFC000000, all others 0).
- R2: A write to word index 0 (control) sets enable from bit 0, mono from bit 1, the interrupt mask from bits 4:3, the TFT select from bit 7 and the palette mode from bits 21:20. Bits under 0x01CFF300 are kept as written. A read returns these fields in the same places, the TFT bit repeated at bit 23, and the kept bits, ORed with 0xFE000C34.
- R3: Writes to word indices 1 and 2 put bits 9:0 on cfg_width_m1 and cfg_height_m1, and keep bits 31:10 for read-back in place. A read of index 1 also forces bits 3:0 to one.
- R4: Word index 3 stores the whole written word on cfg_raw_timing and reads back with bits 31:26 forced to one.
- R5: A read of word index 4 (status) gives frame-done at bit 0, sync-error at bit 2 and palette-done at bit 6. A write to it changes nothing.
- R6: Word index 5 (sub-panel) keeps only the written bits under 0xA1FFFFFF.
- R7: irq is registered. It is high one cycle after frame-done is set with mask bit 0, or palette-done is set with mask bit 1, or sync-error is set (sync-error has no mask bit).
- R8: A control write that changes enable from 1 to 0 clears sync-error. It sets frame-done unless the newly written palette mode is 1. enable_fell pulses for one cycle, in the same cycle that cfg_enable falls.
- R9: A control write that changes enable from 0 to 1 clears frame-done and palette-done. enable_rose pulses for one cycle, in the same cycle that cfg_enable rises.
- R10: A read of a word index above 5 returns zero, and a write to one changes no register.
- R11: Event pulses set their flags and the flags stay set. If an enable change lands in the same cycle as an event, the clearing or setting from the enable change wins.
- R12: reg_rdata is loaded in the cycle after reg_rd is high. It shows the state from before any write made in the same cycle, and it is zero after a cycle without reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| ev_frame_done | input | 1 | Frame engine finished a frame |
| ev_palette_loaded | input | 1 | Palette has been fetched |
| ev_sync_err | input | 1 | Frame engine lost sync |
| cfg_enable | output | 1 | Controller enable |
| cfg_mono | output | 1 | Monochrome panel select |
| cfg_tft | output | 1 | Active-matrix panel select |
| cfg_irq_mask | output | 2 | Mask: bit 0 frame-done, bit 1 palette-done |
| cfg_pal_mode | output | 2 | Palette loading mode |
| cfg_width_m1 | output | SIZE_W | Panel width minus one |
| cfg_height_m1 | output | SIZE_W | Panel height minus one |
| cfg_raw_timing | output | 32 | Raw timing word |
| cfg_subpanel | output | 32 | Masked sub-panel word |
| enable_rose | output | 1 | One-cycle pulse when enable turns on |
| enable_fell | output | 1 | One-cycle pulse when enable turns off |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle the rules that tie flags to enable changes and flags to the interrupt. Sync-error always raises irq on the next cycle. With no flag set, irq stays low. Each enable pulse arrives with its flags already cleared. A status write with nothing else happening leaves the flags alone, and the two pulses never occur together. Other behaviour can only be shown by the bench's scenarios: the read-back forcing and mirroring, the write masks, the palette-mode exception on disable, precedence when an event and an enable change share a cycle, and unmapped accesses.

// File: rtl/lcdr_pkg.sv
// Shared constants of the LCD controller register file.
// Assumes word-indexed register access; masks are fixed at 32 bits.
package lcdr_pkg;
    localparam int unsigned IDX_CTRL   = 0;
    localparam int unsigned IDX_SIZE_W = 1;
    localparam int unsigned IDX_SIZE_H = 2;
    localparam int unsigned IDX_RAW    = 3;
    localparam int unsigned IDX_STAT   = 4;
    localparam int unsigned IDX_SUB    = 5;

    localparam logic [31:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [31:0] CTRL_RD_FORCE  = 32'hFE00_0C34;
    localparam logic [31:0] SIZE0_RD_FORCE = 32'h0000_000F;
    localparam logic [31:0] RAW_RD_FORCE   = 32'hFC00_0000;
    localparam logic [31:0] SUB_KEEP_MASK  = 32'hA1FF_FFFF;

    localparam logic [1:0] PAL_MODE_ONLY = 2'd1;
endpackage

// File: rtl/lcdr_ctrl_reg.sv
// Control word: decoded fields, retained bits and enable-change detection.
// Assumes at most one write per cycle; the change strobes are combinational.
module lcdr_ctrl_reg
    import lcdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic        en_q,
    output logic        mono_q,
    output logic        tft_q,
    output logic [1:0]  mask_q,
    output logic [1:0]  pal_q,
    output logic [31:0] keep_q,
    output logic        turn_on,
    output logic        turn_off,
    output logic [1:0]  new_pal,
    output logic        rose_q,
    output logic        fell_q
);
    // Detect a change of enable in the current write.
    always_comb begin
        turn_on  = wr && wdata[0] && !en_q;
        turn_off = wr && !wdata[0] && en_q;
        new_pal  = wdata[21:20];
    end

    // Hold the control fields and emit the enable pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mono_q <= 1'b0;
            tft_q  <= 1'b0;
            mask_q <= 2'b00;
            pal_q  <= 2'b00;
            keep_q <= '0;
            rose_q <= 1'b0;
            fell_q <= 1'b0;
        end else begin
            rose_q <= turn_on;
            fell_q <= turn_off;
            if (wr) begin
                en_q   <= wdata[0];
                mono_q <= wdata[1];
                mask_q <= wdata[4:3];
                tft_q  <= wdata[7];
                pal_q  <= wdata[21:20];
                keep_q <= wdata & CTRL_KEEP_MASK;
            end
        end
    end
endmodule

// File: rtl/lcdr_geom_regs.sv
// Size, raw timing and sub-panel words.
// Assumes SIZE_W below 32; the upper bits of each size word are kept for read-back.
module lcdr_geom_regs
    import lcdr_pkg::*;
#(
    parameter int unsigned SIZE_W = 10,
    localparam int unsigned HI_W  = 32 - SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_size,
    input  logic              wr_raw,
    input  logic              wr_sub,
    input  logic [31:0]       wdata,
    output logic [SIZE_W-1:0] size_m1 [2],
    output logic [HI_W-1:0]   size_hi [2],
    output logic [31:0]       raw_q,
    output logic [31:0]       sub_q
);
    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_size
            // One size word: low bits are the size minus one, the rest are kept.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    size_m1[gi] <= '0;
                    size_hi[gi] <= '0;
                end else if (wr_size[gi]) begin
                    size_m1[gi] <= wdata[SIZE_W-1:0];
                    size_hi[gi] <= wdata[31:SIZE_W];
                end
            end
        end
    endgenerate

    // Raw timing word and masked sub-panel word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            sub_q <= '0;
        end else begin
            if (wr_raw) raw_q <= wdata;
            if (wr_sub) sub_q <= wdata & SUB_KEEP_MASK;
        end
    end
endmodule

// File: rtl/lcdr_status_irq.sv
// Sticky status flags and the registered combined interrupt.
// Assumes an enable change overrides an event arriving in the same cycle.
module lcdr_status_irq
    import lcdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_frame,
    input  logic       ev_pal,
    input  logic       ev_sync,
    input  logic       turn_on,
    input  logic       turn_off,
    input  logic [1:0] new_pal,
    input  logic [1:0] mask,
    output logic       frame_q,
    output logic       pal_q,
    output logic       sync_q,
    output logic       irq_q
);
    logic frame_d, pal_d, sync_d;

    // Next flag values: events set, enable changes take precedence.
    always_comb begin
        frame_d = frame_q | ev_frame;
        pal_d   = pal_q | ev_pal;
        sync_d  = sync_q | ev_sync;
        if (turn_on) begin
            frame_d = 1'b0;
            pal_d   = 1'b0;
        end
        if (turn_off) begin
            sync_d = 1'b0;
            if (new_pal != PAL_MODE_ONLY) frame_d = 1'b1;
        end
    end

    // Register flags and recompute the interrupt from the current flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            pal_q   <= 1'b0;
            sync_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            frame_q <= frame_d;
            pal_q   <= pal_d;
            sync_q  <= sync_d;
            irq_q   <= (frame_q && mask[0]) || (pal_q && mask[1]) || sync_q;
        end
    end
endmodule

// File: rtl/lcdr_regfile.sv
// LCD controller register file: write decode, read mux and forced read bits.
// Assumes word-indexed access and one registered read per strobe.
module lcdr_regfile
    import lcdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    input  logic              ev_frame_done,
    input  logic              ev_palette_loaded,
    input  logic              ev_sync_err,
    output logic              cfg_enable,
    output logic              cfg_mono,
    output logic              cfg_tft,
    output logic [1:0]        cfg_irq_mask,
    output logic [1:0]        cfg_pal_mode,
    output logic [SIZE_W-1:0] cfg_width_m1,
    output logic [SIZE_W-1:0] cfg_height_m1,
    output logic [31:0]       cfg_raw_timing,
    output logic [31:0]       cfg_subpanel,
    output logic              enable_rose,
    output logic              enable_fell,
    output logic              irq
);
    localparam int unsigned HI_W = 32 - SIZE_W;

    logic [31:0]       keep_q;
    logic              turn_on, turn_off;
    logic [1:0]        new_pal;
    logic [SIZE_W-1:0] size_m1 [2];
    logic [HI_W-1:0]   size_hi [2];
    logic              st_frame, st_pal, st_sync;
    logic              wr_ctrl, wr_raw, wr_sub;
    logic [1:0]        wr_size;
    logic [31:0]       rd_mux;

    // Write strobe per register.
    always_comb begin
        wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(IDX_CTRL));
        wr_size[0] = reg_wr && (reg_addr == ADDR_W'(IDX_SIZE_W));
        wr_size[1] = reg_wr && (reg_addr == ADDR_W'(IDX_SIZE_H));
        wr_raw     = reg_wr && (reg_addr == ADDR_W'(IDX_RAW));
        wr_sub     = reg_wr && (reg_addr == ADDR_W'(IDX_SUB));
    end

    lcdr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ctrl),
        .wdata    (reg_wdata),
        .en_q     (cfg_enable),
        .mono_q   (cfg_mono),
        .tft_q    (cfg_tft),
        .mask_q   (cfg_irq_mask),
        .pal_q    (cfg_pal_mode),
        .keep_q   (keep_q),
        .turn_on  (turn_on),
        .turn_off (turn_off),
        .new_pal  (new_pal),
        .rose_q   (enable_rose),
        .fell_q   (enable_fell)
    );

    lcdr_geom_regs #(.SIZE_W(SIZE_W)) u_geom (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_size (wr_size),
        .wr_raw  (wr_raw),
        .wr_sub  (wr_sub),
        .wdata   (reg_wdata),
        .size_m1 (size_m1),
        .size_hi (size_hi),
        .raw_q   (cfg_raw_timing),
        .sub_q   (cfg_subpanel)
    );

    lcdr_status_irq u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_frame (ev_frame_done),
        .ev_pal   (ev_palette_loaded),
        .ev_sync  (ev_sync_err),
        .turn_on  (turn_on),
        .turn_off (turn_off),
        .new_pal  (new_pal),
        .mask     (cfg_irq_mask),
        .frame_q  (st_frame),
        .pal_q    (st_pal),
        .sync_q   (st_sync),
        .irq_q    (irq)
    );

    assign cfg_width_m1  = size_m1[0];
    assign cfg_height_m1 = size_m1[1];

    // Assemble the read value of the addressed register.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADDR_W'(IDX_CTRL): begin
                rd_mux = keep_q | CTRL_RD_FORCE;
                rd_mux[0]     = rd_mux[0] | cfg_enable;
                rd_mux[1]     = rd_mux[1] | cfg_mono;
                rd_mux[4:3]   = rd_mux[4:3] | cfg_irq_mask;
                rd_mux[7]     = rd_mux[7] | cfg_tft;
                rd_mux[21:20] = rd_mux[21:20] | cfg_pal_mode;
                rd_mux[23]    = rd_mux[23] | cfg_tft;
            end
            ADDR_W'(IDX_SIZE_W): rd_mux = {size_hi[0], size_m1[0]} | SIZE0_RD_FORCE;
            ADDR_W'(IDX_SIZE_H): rd_mux = {size_hi[1], size_m1[1]};
            ADDR_W'(IDX_RAW):    rd_mux = cfg_raw_timing | RAW_RD_FORCE;
            ADDR_W'(IDX_STAT):   rd_mux = {25'd0, st_pal, 3'd0, st_sync, 1'b0, st_frame};
            ADDR_W'(IDX_SUB):    rd_mux = cfg_subpanel;
            default:             rd_mux = '0;
        endcase
    end

    // Register read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= reg_rd ? rd_mux : 32'd0;
    end
endmodule

// File: rtl/lcdr_regfile_chk.sv
// Temporal checks on flags, enable pulses and the interrupt of lcdr_regfile.
module lcdr_regfile_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              ev_frame_done,
    input logic              ev_palette_loaded,
    input logic              ev_sync_err,
    input logic              st_frame,
    input logic              st_pal,
    input logic              st_sync,
    input logic              enable_rose,
    input logic              enable_fell,
    input logic              irq
);
    AST_SYNC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        st_sync |=> irq); // R7
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_sync && !st_frame && !st_pal) |=> !irq); // R7
    AST_FALL_CLEARS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        enable_fell |-> !st_sync); // R8
    AST_RISE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        enable_rose |-> (!st_frame && !st_pal)); // R9
    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(4) && !ev_frame_done && !ev_palette_loaded && !ev_sync_err)
        |=> ($stable(st_frame) && $stable(st_pal) && $stable(st_sync))); // R5
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_rose && enable_fell)); // R8
endmodule

bind lcdr_regfile lcdr_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_addr          (reg_addr),
    .reg_wr            (reg_wr),
    .ev_frame_done     (ev_frame_done),
    .ev_palette_loaded (ev_palette_loaded),
    .ev_sync_err       (ev_sync_err),
    .st_frame          (st_frame),
    .st_pal            (st_pal),
    .st_sync           (st_sync),
    .enable_rose       (enable_rose),
    .enable_fell       (enable_fell),
    .irq               (irq)
);

// File: tb/tb_lcdr_regfile.sv
module tb_lcdr_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] reg_addr = '0;
    logic reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic ev_fd = 0, ev_pd = 0, ev_se = 0;
    logic cfg_enable, cfg_mono, cfg_tft, enable_rose, enable_fell, irq;
    logic [1:0] cfg_irq_mask, cfg_pal_mode;
    logic [9:0] cfg_width_m1, cfg_height_m1;
    logic [31:0] cfg_raw_timing, cfg_subpanel;

    int checks = 0, failures = 0, cycles = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdr_regfile #(.ADDR_W(AW), .SIZE_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ev_frame_done(ev_fd), .ev_palette_loaded(ev_pd), .ev_sync_err(ev_se),
        .cfg_enable(cfg_enable), .cfg_mono(cfg_mono), .cfg_tft(cfg_tft),
        .cfg_irq_mask(cfg_irq_mask), .cfg_pal_mode(cfg_pal_mode),
        .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
        .cfg_raw_timing(cfg_raw_timing), .cfg_subpanel(cfg_subpanel),
        .enable_rose(enable_rose), .enable_fell(enable_fell), .irq(irq));

    // Behavioural reference state.
    int m_en, m_mono, m_tft, m_msk, m_plm, m_w, m_h, m_whi, m_hhi;
    int m_fd, m_pd, m_se, m_irq, m_rise, m_fall;
    bit [31:0] m_keep, m_raw, m_sub, m_rd;

    always @(posedge clk) begin
        bit [31:0] v;
        int nirq;
        if (!rst_n) begin
            m_en = 0; m_mono = 0; m_tft = 0; m_msk = 0; m_plm = 0; m_w = 0; m_h = 0;
            m_whi = 0; m_hhi = 0; m_fd = 0; m_pd = 0; m_se = 0; m_irq = 0;
            m_rise = 0; m_fall = 0; m_keep = 0; m_raw = 0; m_sub = 0; m_rd = 0;
        end else begin
            v = 0;
            if (reg_rd) begin
                case (int'(reg_addr))
                    0: v = 32'(m_tft * 32'h80_0000 + m_plm * 32'h10_0000 + m_tft * 128 + m_msk * 8
                           + m_mono * 2 + m_en) | m_keep | 32'hFE00_0C34;
                    1: v = 32'(m_whi * 1024 + m_w) | 32'hF;
                    2: v = 32'(m_hhi * 1024 + m_h);
                    3: v = m_raw | 32'hFC00_0000;
                    4: v = 32'(m_pd * 64 + m_se * 4 + m_fd);
                    5: v = m_sub;
                    default: v = 0;
                endcase
            end
            nirq = ((m_fd != 0 && m_msk % 2 == 1) || (m_pd != 0 && m_msk / 2 == 1) || m_se != 0) ? 1 : 0;
            m_rise = 0; m_fall = 0;
            if (ev_fd) m_fd = 1;
            if (ev_pd) m_pd = 1;
            if (ev_se) m_se = 1;
            if (reg_wr) begin
                case (int'(reg_addr))
                    0: begin
                        m_mono = int'(reg_wdata[1]); m_msk = int'(reg_wdata[4:3]);
                        m_tft = int'(reg_wdata[7]); m_plm = int'(reg_wdata[21:20]);
                        m_keep = reg_wdata & 32'h01CF_F300;
                        if (int'(reg_wdata[0]) != m_en) begin
                            m_en = int'(reg_wdata[0]);
                            if (m_en == 1) begin m_rise = 1; m_fd = 0; m_pd = 0; end
                            else begin m_fall = 1; m_se = 0; if (m_plm != 1) m_fd = 1; end
                        end
                    end
                    1: begin m_w = int'(reg_wdata[9:0]); m_whi = int'(reg_wdata[31:10]); end
                    2: begin m_h = int'(reg_wdata[9:0]); m_hhi = int'(reg_wdata[31:10]); end
                    3: m_raw = reg_wdata;
                    5: m_sub = reg_wdata & 32'hA1FF_FFFF;
                    default: ;
                endcase
            end
            m_rd = v; m_irq = nirq;
        end
    end

    task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output with the reference model, away from the edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(cur_req, "rdata", reg_rdata, m_rd);
            chk("R7", "irq", 32'(irq), 32'(m_irq));
            chk(cur_req, "pulses", {30'd0, enable_rose, enable_fell}, 32'(m_rise * 2 + m_fall));
            chk("R2", "cfg", {cfg_enable, cfg_mono, cfg_tft, cfg_irq_mask, cfg_pal_mode},
                32'(m_en * 64 + m_mono * 32 + m_tft * 16 + m_msk * 4 + m_plm));
            chk("R3", "sizes", {cfg_width_m1, cfg_height_m1}, 32'(m_w * 1024 + m_h));
            chk("R4", "raw", cfg_raw_timing, m_raw);
            chk("R6", "sub", cfg_subpanel, m_sub);
        end
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input int a, input bit [31:0] d);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, input string req, input bit [31:0] exp);
        reg_addr = AW'(a); reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
        chk(req, "read", reg_rdata, exp);
    endtask

    task automatic pulse(input int which);
        if (which == 0) ev_fd = 1;
        if (which == 1) ev_pd = 1;
        if (which == 2) ev_se = 1;
        @(negedge clk);
        ev_fd = 0; ev_pd = 0; ev_se = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset read-back of forced bits
        cur_req = "R1";
        rd(0, "R1", 32'hFE00_0C34);
        rd(1, "R1", 32'h0000_000F);
        rd(3, "R1", 32'hFC00_0000);
        rd(4, "R1", 32'h0);
        chk("R1", "irq", 32'(irq), 0);
        // R2: all-ones control, mirror of TFT
        cur_req = "R2";
        wr(0, 32'hFFFF_FFFF);
        rd(0, "R2", 32'hFFFF_FFBF);
        wr(0, 32'h0000_0080);
        rd(0, "R2", 32'hFE80_0CB4);
        // R3 / R4 / R6
        cur_req = "R3";
        wr(1, 32'h1234_5678);
        rd(1, "R3", 32'h1234_567F);
        chk("R3", "width", 32'(cfg_width_m1), 32'h278);
        wr(2, 32'h0000_0C01);
        rd(2, "R3", 32'h0000_0C01);
        cur_req = "R4";
        wr(3, 32'h0000_1234);
        rd(3, "R4", 32'hFC00_1234);
        cur_req = "R6";
        wr(5, 32'hFFFF_FFFF);
        rd(5, "R6", 32'hA1FF_FFFF);
        // R10: unmapped write and read
        cur_req = "R10";
        wr(9, 32'hFFFF_FFFF);
        rd(9, "R10", 32'h0);
        rd(5, "R10", 32'hA1FF_FFFF);
        // R9: enable with mask, flags cleared on rise
        cur_req = "R9";
        pulse(0); pulse(1);
        rd(4, "R11", 32'h41);
        wr(0, 32'h0000_0019);
        chk("R9", "rose", 32'(enable_rose), 1);
        rd(4, "R9", 32'h0);
        // R7: masked interrupts
        cur_req = "R7";
        pulse(1);
        @(negedge clk);
        chk("R7", "pal irq", 32'(irq), 1);
        wr(0, 32'h0000_0009);
        @(negedge clk);
        chk("R7", "masked pal", 32'(irq), 0);
        pulse(2);
        @(negedge clk);
        chk("R7", "sync irq", 32'(irq), 1);
        // R5: status write ignored
        cur_req = "R5";
        wr(4, 32'h0);
        rd(4, "R5", 32'h44);
        // R8: disable clears sync, sets frame-done
        cur_req = "R8";
        wr(0, 32'h0);
        chk("R8", "fell", 32'(enable_fell), 1);
        rd(4, "R8", 32'h41);
        // R8: palette-only mode does not set frame-done
        wr(0, 32'h1);
        wr(0, 32'h0010_0000);
        rd(4, "R8", 32'h0);
        // R11: event in same cycle as enable rise loses
        cur_req = "R11";
        ev_fd = 1; ev_se = 1;
        wr(0, 32'h1);
        ev_fd = 0; ev_se = 0;
        rd(4, "R11", 32'h04);
        // R11: sync event in same cycle as disable loses
        ev_se = 1;
        wr(0, 32'h0);
        ev_se = 0;
        rd(4, "R11", 32'h01);
        // R12: read and write to same register in one cycle
        cur_req = "R12";
        reg_addr = AW'(3); reg_wdata = 32'h0000_00AA; reg_wr = 1; reg_rd = 1;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        chk("R12", "old value", reg_rdata, 32'hFC00_1234);
        @(negedge clk);
        chk("R12", "idle zero", reg_rdata, 32'h0);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule